// File: doc/BRIEF.md
# Hot-Plug Expander Sequencer

This block keeps the Hot-Plug signals of every downstream slot in step with an external I/O expander that sits on a byte-level SMBus master engine. The slots' Hot-Plug outputs arrive as one image vector. When any bit of that image differs from the image last sent, the block requests one SMBus write that carries the whole current image. When the expander pulls its active-low interrupt line, the block requests one SMBus read of the whole input image. It then hands that image to the slot logic, together with a one-cycle valid pulse and a per-bit change mask.

The block stays silent until reset has ended and the device has signalled that configuration is done. After that it issues one full write and then one full read, so the shadow images start out coherent. Pending writes go before pending reads. Output edits that arrive while a transaction is in flight are folded into a single follow-up write of the newest image. A failed transaction (NACK or lost arbitration) is requested again a bounded number of times. After that the block gives up and raises a sticky failure flag.

Top module: `hpx_seq`

## Requirements
- R1: After reset `smb_req`, `hp_in`, `hp_in_chg`, `hp_in_valid` and `xfer_fail` are 0. No request is raised before `cfg_done` has been seen high, whatever `hp_out` and `exp_int_n` do.
- R2: After `cfg_done` is first seen, exactly one write of the full `hp_out` image is requested, and then one read, even if the interrupt is inactive.
- R3: Each slot s (0 for port 1, up to NUM_SLOTS-1) owns image bits 4s..4s+3. The output bits, from low to high, are attention indicator, power indicator, power control and interlock. The input bits are attention button, presence, MRL sensor and power fault. Byte k on the bus carries bits 8k..8k+7, and `smb_len` gives the byte count (8 for 15 slots). A change of any `hp_out` bit while idle leads to one write (`smb_rd`=0) whose `smb_wdata` is the whole current image, with the request raised one clock after the change is sampled.
- R4: Changes to `hp_out` made while a transaction is in flight produce exactly one follow-up write, carrying the latest image.
- R5: `exp_int_n` passes through a two-stage synchronizer and is level sensitive. While it stays low, a new read is requested each time the previous one completes.
- R6: When a write and a read are both pending in an idle cycle, the write is requested first.
- R7: On a successful read, `hp_in` takes `smb_rdata`, and `hp_in_chg` equals the old `hp_in` XOR the new value, for exactly one cycle together with `hp_in_valid`=1. At other times `hp_in_chg` is 0 and `hp_in` holds.
- R8: On `smb_done` with `smb_err`=1, the request drops for one cycle and is raised again with the same direction and data, up to MAX_RETRY (3) times. If the last attempt also fails, the transaction is dropped and `xfer_fail` becomes 1 and stays 1 until reset.
- R9: `smb_req` stays high, with `smb_rd` and `smb_wdata` stable, until `smb_done` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Device configuration finished |
| hp_out | input | IMG_W (60) | Hot-Plug output image from slot logic |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| hp_in | output | IMG_W (60) | Last input image read from the expander |
| hp_in_chg | output | IMG_W (60) | Per-bit change mask, valid with hp_in_valid |
| hp_in_valid | output | 1 | One-cycle pulse when hp_in was updated |
| smb_req | output | 1 | Transaction request to the SMBus engine |
| smb_rd | output | 1 | 1 = read, 0 = write |
| smb_len | output | LEN_W (4) | Transaction length in bytes |
| smb_wdata | output | IMG_W (60) | Image to write |
| smb_done | input | 1 | Transaction finished (one-cycle pulse) |
| smb_err | input | 1 | Qualifies smb_done: NACK or arbitration loss |
| smb_rdata | input | IMG_W (60) | Image read, valid with smb_done |
| xfer_fail | output | 1 | Sticky: a transaction failed on every attempt |

## Verification
Each result has a fixed due time. A request is due one clock after the edge that samples an `hp_out` change or the end of configuration, and three clocks after the interrupt falls. A retry request follows two clocks after a failing `smb_done`. `hp_in`, `hp_in_chg` and `hp_in_valid` change at the very edge that samples a good read's `smb_done`. The bench keeps a behavioural cycle model stepped on the same rising edge as the design. It compares every output at the falling edge, where both have settled, so no check depends on guessed delays. Scenario checks then read a log of request rising edges for ordering, merging and retry counts.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  // signals per slot in each direction
  localparam int SIGS_PER_SLOT = 4;

  // bit offsets inside a slot nibble (outputs)
  localparam int OB_ATTN_IND = 0;
  localparam int OB_PWR_IND  = 1;
  localparam int OB_PWR_CTL  = 2;
  localparam int OB_INTERLK  = 3;
  // bit offsets inside a slot nibble (inputs)
  localparam int IB_ATTN_BTN = 0;
  localparam int IB_PRESENT  = 1;
  localparam int IB_MRL      = 2;
  localparam int IB_PWR_FLT  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_RETRY = 2'd2
  } hpx_state_e;

  function automatic int img_bytes(input int bits);
    return (bits + 7) / 8;
  endfunction
endpackage

// File: rtl/hpx_int_sync.sv
module hpx_int_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_n,
  output logic int_act
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], int_n};
  end

  assign int_act = ~sr[STAGES-1];

  // the synchronized level may only report what the pin showed STAGES edges back
  assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_act |-> !$past(int_n, 2));
endmodule

// File: rtl/hpx_out_track.sv
module hpx_out_track #(
  parameter int NUM_SLOTS = 15,
  localparam int IMG_W = NUM_SLOTS * hpx_pkg::SIGS_PER_SLOT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             issue_wr,
  input  logic [IMG_W-1:0] hp_out,
  output logic             wr_need,
  output logic [IMG_W-1:0] img
);
  localparam int SW = hpx_pkg::SIGS_PER_SLOT;

  logic                 force_wr;
  logic [NUM_SLOTS-1:0] slot_dirty;

  // per-slot compare of live outputs against the image last handed to the bus
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign slot_dirty[s] = |(hp_out[s*SW +: SW] ^ img[s*SW +: SW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_wr <= 1'b0;
      img      <= '0;
    end else begin
      if (start)    force_wr <= 1'b1;
      if (issue_wr) begin
        force_wr <= 1'b0;
        img      <= hp_out;
      end
    end
  end

  assign wr_need = force_wr | (|slot_dirty);

  // with nothing owed and the outputs left untouched, no write may appear
  assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_need && !start) |=> ($stable(hp_out) ? !wr_need : 1'b1));
endmodule

// File: rtl/hpx_in_capture.sv
module hpx_in_capture #(
  parameter int IMG_W = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_ok,
  input  logic [IMG_W-1:0] rdata,
  output logic [IMG_W-1:0] hp_in,
  output logic [IMG_W-1:0] hp_in_chg,
  output logic             hp_in_valid
);
  function automatic logic [IMG_W-1:0] delta(input logic [IMG_W-1:0] was,
                                             input logic [IMG_W-1:0] now);
    return was ^ now;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_in       <= '0;
      hp_in_chg   <= '0;
      hp_in_valid <= 1'b0;
    end else begin
      hp_in_valid <= rd_ok;
      hp_in_chg   <= rd_ok ? delta(hp_in, rdata) : '0;
      if (rd_ok) hp_in <= rdata;
    end
  end

  assert_chg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_in_valid |-> (hp_in_chg == '0));
  assert_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(hp_in));
endmodule

// File: rtl/hpx_ctrl.sv
module hpx_ctrl
  import hpx_pkg::*;
#(
  parameter int MAX_RETRY = 3,
  localparam int RW = $clog2(MAX_RETRY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic wr_need,
  input  logic int_act,
  input  logic smb_done,
  input  logic smb_err,
  output logic smb_req,
  output logic op_rd,
  output logic ev_start,
  output logic ev_issue_wr,
  output logic ev_issue_rd,
  output logic ev_rd_ok,
  output logic ev_give_up,
  output logic xfer_fail
);
  hpx_state_e    state;
  logic          started;
  logic          force_rd;
  logic [RW-1:0] retry_cnt;
  logic          fin_ok, fin_bad, last_try;

  assign ev_start    = cfg_done && !started;
  assign ev_issue_wr = (state == ST_IDLE) && started && wr_need;
  assign ev_issue_rd = (state == ST_IDLE) && started && !wr_need && (force_rd || int_act);
  assign fin_ok      = (state == ST_BUSY) && smb_done && !smb_err;
  assign fin_bad     = (state == ST_BUSY) && smb_done && smb_err;
  assign last_try    = (retry_cnt == RW'(MAX_RETRY));
  assign ev_rd_ok    = fin_ok && op_rd;
  assign ev_give_up  = fin_bad && last_try;
  assign smb_req     = (state == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      started   <= 1'b0;
      force_rd  <= 1'b0;
      op_rd     <= 1'b0;
      retry_cnt <= '0;
      xfer_fail <= 1'b0;
    end else begin
      if (ev_start) begin
        started  <= 1'b1;
        force_rd <= 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          if (ev_issue_wr) begin
            state <= ST_BUSY;
            op_rd <= 1'b0;
          end else if (ev_issue_rd) begin
            state    <= ST_BUSY;
            op_rd    <= 1'b1;
            force_rd <= 1'b0;
          end
        end
        ST_BUSY: begin
          if (fin_ok) begin
            state     <= ST_IDLE;
            retry_cnt <= '0;
          end else if (ev_give_up) begin
            state     <= ST_IDLE;
            retry_cnt <= '0;
            xfer_fail <= 1'b1;
          end else if (fin_bad) begin
            state     <= ST_RETRY;
            retry_cnt <= retry_cnt + 1'b1;
          end
        end
        ST_RETRY: state <= ST_BUSY;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_no_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !smb_req);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smb_req && !smb_done) |=> (smb_req && $stable(op_rd)));
  assert_write_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && started && wr_need) |=> (smb_req && !op_rd));
  assert_retry_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RETRY) |=> (smb_req && $stable(op_rd)));
  assert_give_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_give_up |=> (xfer_fail && !smb_req));
  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fail |=> xfer_fail);
endmodule

// File: rtl/hpx_seq.sv
module hpx_seq
  import hpx_pkg::*;
#(
  parameter  int NUM_SLOTS   = 15,
  parameter  int MAX_RETRY   = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int IMG_W       = NUM_SLOTS * SIGS_PER_SLOT,
  localparam int NBYTES      = img_bytes(IMG_W),
  localparam int LEN_W       = $clog2(NBYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic [IMG_W-1:0] hp_out,
  input  logic             exp_int_n,
  output logic [IMG_W-1:0] hp_in,
  output logic [IMG_W-1:0] hp_in_chg,
  output logic             hp_in_valid,
  output logic             smb_req,
  output logic             smb_rd,
  output logic [LEN_W-1:0] smb_len,
  output logic [IMG_W-1:0] smb_wdata,
  input  logic             smb_done,
  input  logic             smb_err,
  input  logic [IMG_W-1:0] smb_rdata,
  output logic             xfer_fail
);
  // named internal events
  logic int_act;
  logic wr_need;
  logic ev_start, ev_issue_wr, ev_issue_rd, ev_rd_ok, ev_give_up;

  hpx_int_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .int_n   (exp_int_n),
    .int_act (int_act)
  );

  hpx_out_track #(.NUM_SLOTS(NUM_SLOTS)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev_start),
    .issue_wr (ev_issue_wr),
    .hp_out   (hp_out),
    .wr_need  (wr_need),
    .img      (smb_wdata)
  );

  hpx_ctrl #(.MAX_RETRY(MAX_RETRY)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_done    (cfg_done),
    .wr_need     (wr_need),
    .int_act     (int_act),
    .smb_done    (smb_done),
    .smb_err     (smb_err),
    .smb_req     (smb_req),
    .op_rd       (smb_rd),
    .ev_start    (ev_start),
    .ev_issue_wr (ev_issue_wr),
    .ev_issue_rd (ev_issue_rd),
    .ev_rd_ok    (ev_rd_ok),
    .ev_give_up  (ev_give_up),
    .xfer_fail   (xfer_fail)
  );

  hpx_in_capture #(.IMG_W(IMG_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_ok       (ev_rd_ok),
    .rdata       (smb_rdata),
    .hp_in       (hp_in),
    .hp_in_chg   (hp_in_chg),
    .hp_in_valid (hp_in_valid)
  );

  assign smb_len = LEN_W'(NBYTES);

  assert_wdata_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smb_req && !smb_done) |=> $stable(smb_wdata));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hp_in_valid |=> !hp_in_valid);
  assert_read_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue_rd |-> !$past(ev_issue_rd));
endmodule

// File: tb/test_hpx_seq.sv
module test_hpx_seq;
  localparam int W     = 60;
  localparam int LAT   = 5;
  localparam int WD    = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_done = 1'b0;
  logic [W-1:0]  hp_out = '0;
  logic          exp_int_n = 1'b1;
  logic [W-1:0]  hp_in, hp_in_chg, smb_wdata;
  logic          hp_in_valid, smb_req, smb_rd, xfer_fail;
  logic [3:0]    smb_len;
  logic          smb_done = 1'b0, smb_err = 1'b0;
  logic [W-1:0]  smb_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  hpx_seq i_hpx_seq (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .hp_out(hp_out),
    .exp_int_n(exp_int_n), .hp_in(hp_in), .hp_in_chg(hp_in_chg),
    .hp_in_valid(hp_in_valid), .smb_req(smb_req), .smb_rd(smb_rd),
    .smb_len(smb_len), .smb_wdata(smb_wdata), .smb_done(smb_done),
    .smb_err(smb_err), .smb_rdata(smb_rdata), .xfer_fail(xfer_fail)
  );

  int total = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic         m_s1, m_s2, m_started, m_fwr, m_frd, m_op, m_valid, m_err;
  int           m_state, m_retry;
  logic [W-1:0] m_img, m_in, m_chg;
  logic         t_act, t_started;
  int           t_state;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_started = 0; m_fwr = 0; m_frd = 0; m_op = 0;
      m_valid = 0; m_err = 0; m_state = 0; m_retry = 0;
      m_img = '0; m_in = '0; m_chg = '0;
    end else begin
      t_act = !m_s2; t_started = m_started; t_state = m_state;
      m_s2 = m_s1; m_s1 = exp_int_n;
      m_valid = 0; m_chg = '0;
      if (cfg_done && !t_started) begin m_started = 1; m_fwr = 1; m_frd = 1; end
      if (t_state == 0) begin
        if (t_started) begin
          if (m_fwr || hp_out != m_img) begin
            m_state = 1; m_op = 0; m_img = hp_out; m_fwr = 0;
          end else if (m_frd || t_act) begin
            m_state = 1; m_op = 1; m_frd = 0;
          end
        end
      end else if (t_state == 1) begin
        if (smb_done) begin
          if (smb_err) begin
            if (m_retry == 3) begin m_err = 1; m_retry = 0; m_state = 0; end
            else begin m_retry++; m_state = 2; end
          end else begin
            m_retry = 0; m_state = 0;
            if (m_op) begin m_chg = m_in ^ smb_rdata; m_in = smb_rdata; m_valid = 1; end
          end
        end
      end else begin
        m_state = 1;
      end
    end
  end

  // ---------------- engine model, log, per-cycle compare ----------------
  logic          log_op[$];
  logic [W-1:0]  log_dat[$];
  logic          req_q = 0;
  int            lat = 0, fail_left = 0, valid_cnt = 0;
  logic [W-1:0]  ext_in = '0, chg_seen = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(smb_req == (m_state == 1), "R9 request level", 64'(smb_req), 64'(m_state == 1));
      if (m_state == 1) chk(smb_rd == m_op, "R6 direction", 64'(smb_rd), 64'(m_op));
      if (m_state == 1 && !m_op) chk(smb_wdata == m_img, "R3 write image", 64'(smb_wdata), 64'(m_img));
      chk(hp_in == m_in, "R7 input image", 64'(hp_in), 64'(m_in));
      chk(hp_in_valid == m_valid, "R7 valid pulse", 64'(hp_in_valid), 64'(m_valid));
      chk(hp_in_chg == m_chg, "R7 change mask", 64'(hp_in_chg), 64'(m_chg));
      chk(xfer_fail == m_err, "R8 fail flag", 64'(xfer_fail), 64'(m_err));
    end
    if (hp_in_valid) begin valid_cnt++; chg_seen = hp_in_chg; end
    if (smb_req && !req_q) begin log_op.push_back(smb_rd); log_dat.push_back(smb_wdata); end
    req_q = smb_req;
    if (smb_done) begin
      smb_done = 0; smb_err = 0;
    end else if (smb_req) begin
      lat++;
      if (lat == LAT) begin
        lat = 0; smb_done = 1; smb_err = (fail_left > 0);
        if (fail_left > 0) fail_left--;
        smb_rdata = ext_in;
      end
    end else begin
      lat = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      chk(0, "watchdog", 64'(cyc), 64'(WD));
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_log();
    log_op.delete(); log_dat.delete();
  endtask

  function automatic int count_rd();
    int c = 0;
    foreach (log_op[i]) if (log_op[i]) c++;
    return c;
  endfunction

  initial begin
    logic [W-1:0] old_in;
    step(3);
    chk(smb_req == 0 && hp_in == '0 && hp_in_valid == 0 && hp_in_chg == '0 && xfer_fail == 0,
        "R1 reset state", 64'(smb_req), 64'd0);
    rst_n = 1;
    // R1: activity before configuration is ignored
    hp_out = 60'h123456789ABCDEF; exp_int_n = 0;
    step(10);
    hp_out = 60'h0FEDCBA98765432; exp_int_n = 1;
    step(10);
    chk(log_op.size() == 0, "R1 no traffic before cfg", 64'(log_op.size()), 64'd0);
    chk(smb_len == 4'd8, "R3 byte length", 64'(smb_len), 64'd8);

    // R2: startup write then read
    ext_in = 60'h0A5A5A5A5A5A5A5;
    cfg_done = 1;
    step(40);
    chk(log_op.size() == 2, "R2 startup count", 64'(log_op.size()), 64'd2);
    if (log_op.size() == 2) begin
      chk(log_op[0] == 0 && log_dat[0] == 60'h0FEDCBA98765432, "R2 first is full write",
          64'(log_dat[0]), 64'h0FEDCBA98765432);
      chk(log_op[1] == 1, "R2 then read", 64'(log_op[1]), 64'd1);
    end
    chk(hp_in == ext_in, "R7 startup image", 64'(hp_in), 64'(ext_in));

    // R3: one bit (slot 1 power indicator, bit 5) changes
    clear_log();
    hp_out = hp_out ^ (60'd1 << 5);
    step(30);
    chk(log_op.size() == 1 && log_op[0] == 0, "R3 single write", 64'(log_op.size()), 64'd1);
    if (log_dat.size() > 0) chk(log_dat[0] == hp_out, "R3 whole image", 64'(log_dat[0]), 64'(hp_out));

    // R4: edits during a write merge into one follow-up
    clear_log();
    hp_out = 60'h111111111111111;
    step(3);
    hp_out = 60'h222222222222222;
    step(1);
    hp_out = 60'h333333333333333;
    step(40);
    chk(log_op.size() == 2, "R4 write count", 64'(log_op.size()), 64'd2);
    if (log_dat.size() == 2) begin
      chk(log_dat[0] == 60'h111111111111111, "R4 first image", 64'(log_dat[0]), 64'h111111111111111);
      chk(log_dat[1] == 60'h333333333333333, "R4 merged image", 64'(log_dat[1]), 64'h333333333333333);
    end

    // R7: single interrupt read, change mask
    clear_log();
    old_in = hp_in; valid_cnt = 0;
    ext_in = 60'h0F0F0F0F0F0F0F0;
    exp_int_n = 0;
    step(3);
    exp_int_n = 1;
    step(30);
    chk(count_rd() == 1, "R5 one read per short pulse", 64'(count_rd()), 64'd1);
    chk(valid_cnt == 1, "R7 one valid pulse", 64'(valid_cnt), 64'd1);
    chk(chg_seen == (old_in ^ ext_in), "R7 mask is old xor new", 64'(chg_seen), 64'(old_in ^ ext_in));
    chk(hp_in == ext_in, "R7 image updated", 64'(hp_in), 64'(ext_in));

    // R5: held level gives repeated reads
    clear_log();
    ext_in = 60'h00000000000FFFF;
    exp_int_n = 0;
    step(25);
    exp_int_n = 1;
    step(30);
    chk(count_rd() >= 2, "R5 repeated reads", 64'(count_rd()), 64'd2);
    chk(log_op.size() == count_rd(), "R5 no writes", 64'(log_op.size()), 64'(count_rd()));

    // R6: write pending and interrupt pending together
    clear_log();
    exp_int_n = 0;
    step(4);
    hp_out = 60'h0ABCABCABCABCAB;
    step(10);
    exp_int_n = 1;
    step(30);
    chk(log_op.size() >= 2, "R6 entries", 64'(log_op.size()), 64'd2);
    if (log_op.size() >= 2) begin
      chk(log_op[0] == 1, "R6 read in flight first", 64'(log_op[0]), 64'd1);
      chk(log_op[1] == 0 && log_dat[1] == 60'h0ABCABCABCABCAB, "R6 write before next read",
          64'(log_op[1]), 64'd0);
    end

    // R8: two failures then success
    clear_log();
    fail_left = 2;
    hp_out = 60'h0C0C0C0C0C0C0C0;
    step(50);
    chk(log_op.size() == 3, "R8 attempts with recovery", 64'(log_op.size()), 64'd3);
    foreach (log_dat[i]) chk(log_op[i] == 0 && log_dat[i] == 60'h0C0C0C0C0C0C0C0,
                             "R8 same transaction", 64'(log_dat[i]), 64'h0C0C0C0C0C0C0C0);
    chk(xfer_fail == 0, "R8 no flag after recovery", 64'(xfer_fail), 64'd0);

    // R8: all attempts fail
    clear_log();
    fail_left = 4;
    hp_out = 60'h0D0D0D0D0D0D0D0;
    step(60);
    chk(log_op.size() == 4, "R8 attempt limit", 64'(log_op.size()), 64'd4);
    chk(xfer_fail == 1, "R8 flag raised", 64'(xfer_fail), 64'd1);
    clear_log();
    hp_out = 60'h0E0E0E0E0E0E0E0;
    step(30);
    chk(log_op.size() == 1 && log_dat[0] == 60'h0E0E0E0E0E0E0E0, "R8 later write proceeds",
        64'(log_op.size()), 64'd1);
    chk(xfer_fail == 1, "R8 flag sticky", 64'(xfer_fail), 64'd1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule